// File: doc/BRIEF.md
# Size-Aware Condition Flag Evaluator

This block derives the condition flags of a processor status word from the operands and the result of the instruction that just completed. The sign of each operand and of the result is taken at the byte, word or dword boundary selected by the instruction. It then forms negative, zero, overflow and carry according to the class of operation: add, subtract/compare, move/logic/shift, signed or unsigned multiply, the mcp add variant, or bit-test. The ALU that produced the result sits elsewhere; this block only sees its inputs and outputs.

The new flags are merged into a registered status word. A per-instruction mask selects which flag bits the instruction may change, and the extend bit is always part of that mask. In extended-arithmetic mode, a zero flag can be cleared but never newly set, so multi-word arithmetic yields a zero flag for the whole chain. The status word updates on a clock edge when `eval_en` is high.

Top module: `cond_flag_eval`

## Requirements
- R1: After reset, `status_q` is all zeros.
- R2: `op_size` 0, 1 and 2 select byte, word and dword, with sign bits 7, 15 and 31. Zero tests look only at the selected low bits. Code 3 yields all-zero computed flags for the sized classes (add, sub, move, mcp).
- R3: For add, the flag bits are C=bit 0, V=bit 1, Z=bit 2 and N=bit 3. When the result sign is 1, N=1, V=1 if both operand signs are 0, and C=1 if both are 1. When the result sign is 0, Z=1 if the sized result is zero, V=1 if both operand signs are 1, and C=1 if either is 1.
- R4: For subtract/compare (`op_class`=1), the R3 rules run on the bitwise-inverted source, and C is then inverted.
- R5: For move/logic/shift (`op_class`=2), only N and Z are computed from the sized result; V and C are computed as 0.
- R6: For a signed multiply (`op_class`=3), the product is {`prod_hi`,`res_val`}. N is product bit 63 and Z=1 if all 64 bits are zero. V=1 if `prod_hi` differs from the sign extension of `res_val`. C is 0.
- R7: For an unsigned multiply (`op_class`=4), N is product bit 63, Z=1 if the 64-bit product is zero, V=1 if `prod_hi` is non-zero, and C is 0.
- R8: For mcp (`op_class`=5), the add rules apply, but the carry outcome goes to the R flag at bit 8, and C is computed as 0.
- R9: For bit-test (`op_class`=6), the bit index is `src_val`[4:0] into `dst_val`. N (bit 3) takes the selected bit, and Z (bit 2) is 1 when that bit and all lower bits are 0. X (bit 4) is cleared, all other status bits are kept, and `flag_mask` is ignored.
- R10: For classes 0 to 5, the status bits in `flag_mask` plus X (bit 4) take the computed flags (X computed 0), and all other bits keep their value.
- R11: With `ext_mode` high, a computed Z of 1 is removed from the mask, so Z keeps its previous value. A computed Z of 0 is written as usual.
- R12: The status word is unchanged when `eval_en` is low, or when `op_class` is 7 (flags live).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_en | input | 1 | Evaluate and write back this cycle |
| op_class | input | 3 | Operation class: 0 add, 1 sub/cmp, 2 move/logic, 3 mul signed, 4 mul unsigned, 5 mcp, 6 bit-test, 7 live |
| op_size | input | 2 | 0 byte, 1 word, 2 dword, 3 none |
| ext_mode | input | 1 | Extended-arithmetic mode (sticky Z) |
| flag_mask | input | STAT_W | Flag bits this instruction may write |
| src_val | input | DATA_W | Source operand, or bit index for bit-test |
| dst_val | input | DATA_W | Destination operand, or tested value for bit-test |
| res_val | input | DATA_W | Result, or low product word |
| prod_hi | input | DATA_W | High product word for multiplies |
| status_q | output | STAT_W | Registered status word |

## Verification
The bench builds the block with DATA_W=32, STAT_W=16 and the multiply flag logic enabled. This keeps all three sign positions and the 64-bit product tests in play, together with a status word wide enough to hold the R flag and untouched upper bits. Biased random operands frequently zero the sized result, or place the sign bits of the selected width in every combination. Directed cases cover bit index 31 and 0, the multiply sign-extension boundary, and size code 3.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
   typedef enum logic [2:0] {
      OPC_ADD  = 3'd0,
      OPC_SUB  = 3'd1,
      OPC_MOVE = 3'd2,
      OPC_MULS = 3'd3,
      OPC_MULU = 3'd4,
      OPC_MCP  = 3'd5,
      OPC_BTST = 3'd6,
      OPC_LIVE = 3'd7
   } opc_e;

   localparam int FB_C = 0;
   localparam int FB_V = 1;
   localparam int FB_Z = 2;
   localparam int FB_N = 3;
   localparam int FB_X = 4;
   localparam int FB_R = 8;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } nzvc_t;
endpackage

// File: rtl/cfe_size_pick.sv
module cfe_size_pick #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] res_i,
   output logic              s_sgn_o,
   output logic              d_sgn_o,
   output logic              r_sgn_o,
   output logic              r_zero_o,
   output logic              valid_o
);
   localparam int BYTE_MSB = 7;
   localparam int WORD_MSB = 15;
   localparam int DWRD_MSB = DATA_W - 1;

   always_comb begin
      s_sgn_o  = 1'b0;
      d_sgn_o  = 1'b0;
      r_sgn_o  = 1'b0;
      r_zero_o = 1'b0;
      valid_o  = 1'b1;
      unique case (size_i)
         2'd0: begin
            s_sgn_o  = src_i[BYTE_MSB];
            d_sgn_o  = dst_i[BYTE_MSB];
            r_sgn_o  = res_i[BYTE_MSB];
            r_zero_o = (res_i[BYTE_MSB:0] == '0);
         end
         2'd1: begin
            s_sgn_o  = src_i[WORD_MSB];
            d_sgn_o  = dst_i[WORD_MSB];
            r_sgn_o  = res_i[WORD_MSB];
            r_zero_o = (res_i[WORD_MSB:0] == '0);
         end
         2'd2: begin
            s_sgn_o  = src_i[DWRD_MSB];
            d_sgn_o  = dst_i[DWRD_MSB];
            r_sgn_o  = res_i[DWRD_MSB];
            r_zero_o = (res_i == '0);
         end
         default: valid_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cfe_sign_flags.sv
module cfe_sign_flags
   import cfe_pkg::*;
(
   input  logic  s_sgn_i,
   input  logic  d_sgn_i,
   input  logic  r_sgn_i,
   input  logic  r_zero_i,
   input  logic  valid_i,
   input  logic  inv_src_i,
   input  logic  logic_only_i,
   output nzvc_t flags_o
);
   logic s_eff;
   nzvc_t raw;

   always_comb begin
      s_eff = s_sgn_i ^ inv_src_i;
      raw   = '0;
      if (r_sgn_i) begin
         raw.n = 1'b1;
         raw.v = ~s_eff & ~d_sgn_i;
         raw.c = s_eff & d_sgn_i;
      end else begin
         raw.z = r_zero_i;
         raw.v = s_eff & d_sgn_i;
         raw.c = s_eff | d_sgn_i;
      end
      raw.c = raw.c ^ inv_src_i;
      if (logic_only_i) begin
         raw.v = 1'b0;
         raw.c = 1'b0;
      end
      flags_o = valid_i ? raw : '0;
   end
endmodule

// File: rtl/cfe_mul_flags.sv
module cfe_mul_flags
   import cfe_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit HAS_MUL = 1'b1
) (
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   input  logic              is_signed_i,
   output nzvc_t             flags_o
);
   generate
      if (HAS_MUL) begin : g_mul
         logic hi_is_ext;
         always_comb begin
            hi_is_ext  = (hi_i == {DATA_W{lo_i[DATA_W-1]}});
            flags_o    = '0;
            flags_o.n  = hi_i[DATA_W-1];
            flags_o.z  = (hi_i == '0) && (lo_i == '0);
            flags_o.v  = is_signed_i ? ~hi_is_ext : (hi_i != '0);
         end
      end else begin : g_nomul
         assign flags_o = '0;
      end
   endgenerate
endmodule

// File: rtl/cfe_bit_flags.sv
module cfe_bit_flags
   import cfe_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic [DATA_W-1:0] idx_i,
   output nzvc_t             flags_o
);
   localparam int IDX_W = $clog2(DATA_W);

   logic [IDX_W-1:0]  sel;
   logic [DATA_W:0]   low_span;

   always_comb begin
      sel       = idx_i[IDX_W-1:0];
      low_span  = ({{DATA_W{1'b0}}, 1'b1} << ({1'b0, sel} + 1'b1)) - 1'b1;
      flags_o   = '0;
      flags_o.n = val_i[sel];
      flags_o.z = ((val_i & low_span[DATA_W-1:0]) == '0);
   end

   logic unused_hi;
   assign unused_hi = ^idx_i[DATA_W-1:IDX_W];
endmodule

// File: rtl/cond_flag_eval.sv
module cond_flag_eval
   import cfe_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int STAT_W  = 16,
   parameter bit HAS_MUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_en,
   input  logic [2:0]        op_class,
   input  logic [1:0]        op_size,
   input  logic              ext_mode,
   input  logic [STAT_W-1:0] flag_mask,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] res_val,
   input  logic [DATA_W-1:0] prod_hi,
   output logic [STAT_W-1:0] status_q
);
   localparam logic [STAT_W-1:0] X_BIT   = STAT_W'(1) << FB_X;
   localparam logic [STAT_W-1:0] Z_BIT   = STAT_W'(1) << FB_Z;
   localparam logic [STAT_W-1:0] BT_CLR  = X_BIT | Z_BIT | (STAT_W'(1) << FB_N);

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_w
      $error("cond_flag_eval: DATA_W must be a power of two of at least 32");
   end
   if (STAT_W <= FB_R) begin : g_bad_s
      $error("cond_flag_eval: STAT_W too narrow for the R flag");
   end

   opc_e  opc;
   logic  s_sgn, d_sgn, r_sgn, r_zero, sz_ok;
   nzvc_t f_arith, f_mul, f_bit, f_sel;
   logic [STAT_W-1:0] new_bits, wmask, next_st;

   assign opc = opc_e'(op_class);

   cfe_size_pick #(.DATA_W(DATA_W)) u_size (
      .size_i(op_size), .src_i(src_val), .dst_i(dst_val), .res_i(res_val),
      .s_sgn_o(s_sgn), .d_sgn_o(d_sgn), .r_sgn_o(r_sgn),
      .r_zero_o(r_zero), .valid_o(sz_ok)
   );

   cfe_sign_flags u_sign (
      .s_sgn_i(s_sgn), .d_sgn_i(d_sgn), .r_sgn_i(r_sgn),
      .r_zero_i(r_zero), .valid_i(sz_ok),
      .inv_src_i(opc == OPC_SUB),
      .logic_only_i(opc == OPC_MOVE),
      .flags_o(f_arith)
   );

   cfe_mul_flags #(.DATA_W(DATA_W), .HAS_MUL(HAS_MUL)) u_mul (
      .lo_i(res_val), .hi_i(prod_hi),
      .is_signed_i(opc == OPC_MULS),
      .flags_o(f_mul)
   );

   cfe_bit_flags #(.DATA_W(DATA_W)) u_bit (
      .val_i(dst_val), .idx_i(src_val), .flags_o(f_bit)
   );

   always_comb begin
      unique case (opc)
         OPC_MULS, OPC_MULU: f_sel = f_mul;
         OPC_BTST:           f_sel = f_bit;
         default:            f_sel = f_arith;
      endcase

      new_bits        = '0;
      new_bits[FB_N]  = f_sel.n;
      new_bits[FB_Z]  = f_sel.z;
      new_bits[FB_V]  = f_sel.v;
      if (opc == OPC_MCP) new_bits[FB_R] = f_sel.c;
      else                new_bits[FB_C] = f_sel.c;

      wmask = flag_mask | X_BIT;
      if (ext_mode && f_sel.z) wmask = wmask & ~Z_BIT;

      unique case (opc)
         OPC_LIVE: next_st = status_q;
         OPC_BTST: next_st = (status_q & ~BT_CLR) | (new_bits & BT_CLR);
         default:  next_st = (status_q & ~wmask) | (new_bits & wmask);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       status_q <= '0;
      else if (eval_en) status_q <= next_st;
   end
endmodule

// File: rtl/cond_flag_eval_chk.sv
module cond_flag_eval_chk
   import cfe_pkg::*;
#(
   parameter int STAT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eval_en,
   input logic [2:0]        op_class,
   input logic              ext_mode,
   input logic [STAT_W-1:0] flag_mask,
   input logic [STAT_W-1:0] status_q
);
   localparam logic [STAT_W-1:0] XB  = STAT_W'(1) << FB_X;
   localparam logic [STAT_W-1:0] BTK = ~(XB | (STAT_W'(1) << FB_Z) | (STAT_W'(1) << FB_N));

   logic masked_op;
   assign masked_op = (op_class <= 3'd5);

   always_ff @(posedge clk) begin
      if (!rst_n) ;
      else assert (^status_q !== 1'bx) else $error("status unknown after reset R1");
   end

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval_en || op_class == 3'd7) |=> $stable(status_q));

   p_x_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && op_class != 3'd7) |=> !status_q[FB_X]);

   p_unmasked_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && masked_op) |=>
      (((status_q ^ $past(status_q)) & ~($past(flag_mask) | XB)) == '0));

   p_btst_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && op_class == 3'd6) |=>
      (((status_q ^ $past(status_q)) & BTK) == '0));

   p_z_no_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && masked_op && ext_mode && !status_q[FB_Z]) |=> !status_q[FB_Z]);
endmodule

bind cond_flag_eval cond_flag_eval_chk #(.STAT_W(STAT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .op_class(op_class),
   .ext_mode(ext_mode), .flag_mask(flag_mask), .status_q(status_q)
);

// File: tb/sim_cond_flag_eval.sv
`timescale 1ns/1ps
module sim_cond_flag_eval;
   localparam int DW = 32;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          eval_en;
   logic [2:0]    op_class;
   logic [1:0]    op_size;
   logic          ext_mode;
   logic [SW-1:0] flag_mask;
   logic [DW-1:0] src_val, dst_val, res_val, prod_hi;
   logic [SW-1:0] status_q;

   int total = 0;
   int bad   = 0;
   logic [SW-1:0] model_st;

   always #10 clk = ~clk;

   cond_flag_eval #(.DATA_W(DW), .STAT_W(SW), .HAS_MUL(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .op_class(op_class),
      .op_size(op_size), .ext_mode(ext_mode), .flag_mask(flag_mask),
      .src_val(src_val), .dst_val(dst_val), .res_val(res_val),
      .prod_hi(prod_hi), .status_q(status_q)
   );

   // Reference flags per the requirements; bit map C0 V1 Z2 N3 X4 R8.
   function automatic logic [SW-1:0] ref_next(
      logic [SW-1:0] st, logic en, logic [2:0] op, logic [1:0] sz, logic ext,
      logic [SW-1:0] msk, logic [DW-1:0] s, logic [DW-1:0] d,
      logic [DW-1:0] r, logic [DW-1:0] h);
      int sb;
      logic [DW-1:0] szm;
      logic ss, ds, rs, rz, n, z, v, c;
      logic [63:0] prod;
      logic [SW-1:0] nf, m;
      int idx;
      if (!en || op == 3'd7) return st;
      n = 0; z = 0; v = 0; c = 0;
      if (op == 3'd6) begin
         idx = int'(s[4:0]);
         n = d[idx];
         z = 1'b1;
         for (int i = 0; i <= idx; i++) if (d[i]) z = 1'b0;
         nf = st;
         nf[4] = 1'b0; nf[3] = n; nf[2] = z;
         return nf;
      end
      prod = {h, r};
      if (op == 3'd3 || op == 3'd4) begin
         n = prod[63];
         z = (prod == 64'd0);
         if (op == 3'd3) v = (h != (r[31] ? 32'hFFFF_FFFF : 32'h0));
         else            v = (h != 32'd0);
      end else if (sz != 2'd3) begin
         sb  = (sz == 2'd0) ? 7 : (sz == 2'd1) ? 15 : 31;
         szm = (sz == 2'd2) ? 32'hFFFF_FFFF : ((32'd1 << (sb + 1)) - 32'd1);
         ss = s[sb]; ds = d[sb]; rs = r[sb]; rz = ((r & szm) == 0);
         if (op == 3'd1) ss = ~ss;
         if (rs) begin
            n = 1; v = !ss && !ds; c = ss && ds;
         end else begin
            z = rz; v = ss && ds; c = ss || ds;
         end
         if (op == 3'd1) c = ~c;
         if (op == 3'd2) begin v = 0; c = 0; end
      end
      nf = '0;
      nf[3] = n; nf[2] = z; nf[1] = v;
      if (op == 3'd5) nf[8] = c; else nf[0] = c;
      m = msk | 16'h0010;
      if (ext && z) m[2] = 1'b0;
      return (st & ~m) | (nf & m);
   endfunction

   function automatic string op_tag(logic [2:0] op);
      case (op)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         3'd6: return "R9";
         default: return "R12";
      endcase
   endfunction

   task automatic step(input logic en, input logic [2:0] op, input logic [1:0] sz,
                       input logic ext, input logic [SW-1:0] msk,
                       input logic [DW-1:0] s, input logic [DW-1:0] d,
                       input logic [DW-1:0] r, input logic [DW-1:0] h,
                       input string tag);
      logic [SW-1:0] exp_st;
      eval_en = en; op_class = op; op_size = sz; ext_mode = ext;
      flag_mask = msk; src_val = s; dst_val = d; res_val = r; prod_hi = h;
      exp_st = ref_next(model_st, en, op, sz, ext, msk, s, d, r, h);
      @(posedge clk); #1;
      model_st = exp_st;
      total++;
      if (status_q !== exp_st) begin
         bad++;
         $display("FAIL %s op=%0d sz=%0d actual=%h expected=%h", tag, op, sz, status_q, exp_st);
      end
   endtask

   function automatic logic [DW-1:0] bias(logic [DW-1:0] x);
      case ($urandom % 6)
         0: return 32'h0;
         1: return x & 32'hFFFF_FF00;
         2: return x & 32'hFFFF_0000;
         3: return x | 32'h0000_8080;
         default: return x;
      endcase
   endfunction

   initial begin
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; eval_en = 0; op_class = 0; op_size = 0; ext_mode = 0;
      flag_mask = 0; src_val = 0; dst_val = 0; res_val = 0; prod_hi = 0;
      model_st = '0;
      repeat (3) @(posedge clk);
      #1; rst_n = 1;
      total++;
      if (status_q !== 16'h0) begin
         bad++; $display("FAIL R1 actual=%h expected=0000", status_q);
      end
      // fill status so later merges have something to keep
      step(1, 3'd0, 2'd0, 0, 16'hFFEF, 32'h80, 32'h80, 32'h00, 0, "R3");
      step(1, 3'd0, 2'd0, 0, 16'h000F, 32'h00, 32'h00, 32'h80, 0, "R2");
      step(1, 3'd0, 2'd1, 0, 16'h000F, 32'h8000, 32'h0, 32'h1_0000, 0, "R2");
      step(1, 3'd0, 2'd3, 0, 16'h010F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R2");
      step(1, 3'd1, 2'd2, 0, 16'h000F, 32'h5, 32'h5, 32'h0, 0, "R4");
      step(1, 3'd2, 2'd0, 0, 16'h000F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h100, 0, "R5");
      step(1, 3'd3, 2'd2, 0, 16'h000F, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
      step(1, 3'd3, 2'd2, 0, 16'h000F, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R6");
      step(1, 3'd4, 2'd2, 0, 16'h000F, 0, 0, 32'h0, 32'h1, "R7");
      step(1, 3'd5, 2'd2, 0, 16'h010F, 32'h8000_0000, 32'h8000_0000, 32'h1, 0, "R8");
      step(1, 3'd6, 2'd0, 0, 16'h0000, 32'd31, 32'h8000_0000, 0, 0, "R9");
      step(1, 3'd6, 2'd0, 0, 16'hFFFF, 32'd0, 32'hFFFF_FFFE, 0, 0, "R9");
      step(1, 3'd0, 2'd2, 0, 16'h0004, 0, 0, 32'h0, 0, "R10");
      step(1, 3'd0, 2'd2, 1, 16'h0004, 0, 0, 32'h1, 0, "R11");
      step(1, 3'd0, 2'd2, 1, 16'h0004, 0, 0, 32'h0, 0, "R11");
      step(1, 3'd7, 2'd2, 0, 16'hFFFF, 0, 0, 0, 0, "R12");
      step(0, 3'd0, 2'd2, 0, 16'hFFFF, 32'hFFFF_FFFF, 0, 0, 0, "R12");
      for (int k = 0; k < 600; k++) begin
         logic [2:0] op;
         op = 3'($urandom % 8);
         step(($urandom % 8) != 0, op, 2'($urandom % 4), ($urandom % 3) == 0,
              16'($urandom), bias($urandom), bias($urandom), bias($urandom),
              bias($urandom), op_tag(op));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule